// File: doc/BRIEF.md
# Interrupt Enable Flag Controller

This block holds the interrupt enable state of a CPU core. The instruction decoder and the interrupt acknowledge logic send it single-cycle operation strobes. The block updates two flags from them: a master enable and a backup copy. The backup copy lets the master enable be saved while a nonmaskable interrupt is serviced and restored when the service routine returns with RETN.

The block also holds the configuration that decides which maskable request lines reach the core:
- a per-line request enable register;
- an assigned-vector base register;
- the 8-bit interrupt page register and its 16-bit extension.

All four are reached through a byte-wide register port. The block gates the active-low maskable request lines and passes the nonmaskable request through ungated. When the core executes a load of A or R from the interrupt page register, the block presents the backup flag for the core to copy into its parity/overflow flag.

Several strobes may arrive in the same cycle. A fixed priority resolves them, so the flag update is always defined.

Top module: `irq_enable_ctrl`

## Requirements
- R1: Reset leaves both flags at 0 and all configuration registers at 0. Reset is either `rst_ni` low or a one-cycle `op_reset_i` pulse, and takes effect on the next clock edge.
- R2: A trap strobe clears both the master flag and the backup flag.
- R3: A nonmaskable acknowledge loads the backup flag with the master flag's value from before the edge, and clears the master flag.
- R4: A RETN strobe copies the backup flag into the master flag. The backup flag keeps its value.
- R5: A maskable acknowledge clears both flags.
- R6: EI sets both flags to 1. DI clears both flags to 0.
- R7: RETI and RET strobes leave both flags unchanged.
- R8: While `op_ld_ai_i` is high, `pv_we_o` is 1 and `pv_o` equals the backup flag in the same cycle. After that cycle both flags are unchanged.
- R9: Register address 0 is the request enable register. Bits 3:0 hold the enables for lines 3 to 0. Bits 7:4 read as 0, and writes to them are dropped.
- R10: Register address 1 is the vector base register. Bits 7:1 store base address bits 15:9, which also appear on `vec_base_o`. Bit 0 reads as 0.
- R11: Address 2 holds the interrupt page register. Addresses 3 and 4 hold the low and high bytes of the 16-bit extension. Addresses 5 to 7 read 0, and writes to them change nothing.
- R12: `irq_req_o[n]` is 1 exactly when the master flag is 1, enable bit n is 1 and `int_n_i[n]` is low. `nmi_req_o` is the inverse of `nmi_n_i` and is never gated.
- R13: When several strobes coincide, the priority from highest to lowest is reset, nonmaskable acknowledge, trap, maskable acknowledge, EI, DI, RETN. A configuration write in the same cycle as `op_reset_i` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_reset_i | input | 1 | Synchronous reset strobe |
| op_trap_i | input | 1 | Trap taken |
| op_nmi_ack_i | input | 1 | Nonmaskable interrupt acknowledged |
| op_int_ack_i | input | 1 | Maskable interrupt acknowledged |
| op_retn_i | input | 1 | RETN executed |
| op_reti_i | input | 1 | RETI executed |
| op_ret_i | input | 1 | RET executed |
| op_ei_i | input | 1 | EI executed |
| op_di_i | input | 1 | DI executed |
| op_ld_ai_i | input | 1 | Load A or R from the page register |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data (combinational) |
| int_n_i | input | 4 | Maskable request lines, active low |
| nmi_n_i | input | 1 | Nonmaskable request, active low |
| irq_req_o | output | 4 | Gated maskable requests, active high |
| nmi_req_o | output | 1 | Nonmaskable request, active high |
| ief1_o | output | 1 | Master enable flag |
| ief2_o | output | 1 | Backup flag |
| pv_o | output | 1 | Value for the parity/overflow flag |
| pv_we_o | output | 1 | Parity/overflow flag load strobe |
| vec_base_o | output | 7 | Vector base address bits 15:9 |
| i_reg_o | output | 8 | Interrupt page register |
| i_ext_o | output | 16 | Interrupt page extension |

## Verification
A wrong flag state shows up one edge after the strobe that caused it, on `ief1_o` and `ief2_o`. It is also visible in the same cycle on `irq_req_o`, which drops or leaks requests.

A wrong backup flag may stay hidden until a later RETN or a load of A from the page register. For that reason every nonmaskable scenario is closed with one of those two operations, so that the saved value reaches a port.

Configuration faults appear on `cfg_rdata_o` as soon as the address is driven. They also appear in the gating pattern on the following cycle.

// File: rtl/irq_en_pkg.sv
package irq_en_pkg;
  localparam int unsigned CFG_AW = 3;

  localparam logic [CFG_AW-1:0] ADDR_REQ_EN = 3'd0;
  localparam logic [CFG_AW-1:0] ADDR_VBASE  = 3'd1;
  localparam logic [CFG_AW-1:0] ADDR_IPAGE  = 3'd2;
  localparam logic [CFG_AW-1:0] ADDR_IEXT_L = 3'd3;
  localparam logic [CFG_AW-1:0] ADDR_IEXT_H = 3'd4;

  typedef struct packed {
    logic rst;
    logic nmi_ack;
    logic trap;
    logic int_ack;
    logic ei;
    logic di;
    logic retn;
    logic reti;
    logic ret;
    logic ld_ai;
  } irq_ops_t;

  typedef enum logic [2:0] {
    UPD_HOLD,
    UPD_CLEAR,
    UPD_SAVE,
    UPD_SET,
    UPD_RESTORE
  } flag_upd_e;
endpackage

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_en_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  irq_ops_t ops_i,
  output logic     ief1_o,
  output logic     ief2_o
);
  flag_upd_e upd;
  logic      ief1_q, ief2_q;
  logic      ief1_d, ief2_d;

  // fixed priority resolution of coincident strobes
  always_comb begin
    if (ops_i.rst)                          upd = UPD_CLEAR;
    else if (ops_i.nmi_ack)                 upd = UPD_SAVE;
    else if (ops_i.trap || ops_i.int_ack)   upd = UPD_CLEAR;
    else if (ops_i.ei)                      upd = UPD_SET;
    else if (ops_i.di)                      upd = UPD_CLEAR;
    else if (ops_i.retn)                    upd = UPD_RESTORE;
    else if (ops_i.reti || ops_i.ret || ops_i.ld_ai) upd = UPD_HOLD;
    else                                    upd = UPD_HOLD;
  end

  always_comb begin
    ief1_d = ief1_q;
    ief2_d = ief2_q;
    unique case (upd)
      UPD_CLEAR:   begin ief1_d = 1'b0;   ief2_d = 1'b0;   end
      UPD_SAVE:    begin ief1_d = 1'b0;   ief2_d = ief1_q; end
      UPD_SET:     begin ief1_d = 1'b1;   ief2_d = 1'b1;   end
      UPD_RESTORE: begin ief1_d = ief2_q;                  end
      default:     ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ief1_q <= 1'b0;
      ief2_q <= 1'b0;
    end else begin
      ief1_q <= ief1_d;
      ief2_q <= ief2_d;
    end
  end

  assign ief1_o = ief1_q;
  assign ief2_o = ief2_q;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_en_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned DW        = 8,
  parameter int unsigned EXT_W     = 16,
  parameter int unsigned VB_W      = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NUM_LINES-1:0] req_en_o,
  output logic [VB_W-1:0]   vbase_o,
  output logic [DW-1:0]     ipage_o,
  output logic [EXT_W-1:0]  iext_o
);
  localparam int unsigned EN_PAD = DW - NUM_LINES;
  localparam int unsigned VB_PAD = DW - VB_W;

  logic [NUM_LINES-1:0] req_en_q;
  logic [VB_W-1:0]      vbase_q;
  logic [DW-1:0]        ipage_q;
  logic [EXT_W-1:0]     iext_q;
  logic                 wr;

  assign wr = we_i && !srst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_en_q <= '0;
      vbase_q  <= '0;
      ipage_q  <= '0;
      iext_q   <= '0;
    end else if (srst_i) begin
      req_en_q <= '0;
      vbase_q  <= '0;
      ipage_q  <= '0;
      iext_q   <= '0;
    end else if (wr) begin
      unique case (addr_i)
        ADDR_REQ_EN: req_en_q        <= wdata_i[NUM_LINES-1:0];
        ADDR_VBASE:  vbase_q         <= wdata_i[DW-1:VB_PAD];
        ADDR_IPAGE:  ipage_q         <= wdata_i;
        ADDR_IEXT_L: iext_q[DW-1:0]  <= wdata_i;
        ADDR_IEXT_H: iext_q[EXT_W-1:DW] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_REQ_EN: rdata_o = {{EN_PAD{1'b0}}, req_en_q};
      ADDR_VBASE:  rdata_o = {vbase_q, {VB_PAD{1'b0}}};
      ADDR_IPAGE:  rdata_o = ipage_q;
      ADDR_IEXT_L: rdata_o = iext_q[DW-1:0];
      ADDR_IEXT_H: rdata_o = iext_q[EXT_W-1:DW];
      default:     rdata_o = '0;
    endcase
  end

  assign req_en_o = req_en_q;
  assign vbase_o  = vbase_q;
  assign ipage_o  = ipage_q;
  assign iext_o   = iext_q;
endmodule

// File: rtl/irq_line_gate.sv
module irq_line_gate #(
  parameter int unsigned NUM_LINES = 4
) (
  input  logic                 master_en_i,
  input  logic [NUM_LINES-1:0] line_en_i,
  input  logic [NUM_LINES-1:0] line_n_i,
  input  logic                 nmi_n_i,
  output logic [NUM_LINES-1:0] req_o,
  output logic                 nmi_req_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign req_o[g] = master_en_i & line_en_i[g] & ~line_n_i[g];
  end

  // nonmaskable path bypasses all enables
  assign nmi_req_o = ~nmi_n_i;
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
  import irq_en_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned DW        = 8,
  parameter int unsigned EXT_W     = 16,
  parameter int unsigned VB_W      = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 op_reset_i,
  input  logic                 op_trap_i,
  input  logic                 op_nmi_ack_i,
  input  logic                 op_int_ack_i,
  input  logic                 op_retn_i,
  input  logic                 op_reti_i,
  input  logic                 op_ret_i,
  input  logic                 op_ei_i,
  input  logic                 op_di_i,
  input  logic                 op_ld_ai_i,
  input  logic                 cfg_we_i,
  input  logic [CFG_AW-1:0]    cfg_addr_i,
  input  logic [DW-1:0]        cfg_wdata_i,
  output logic [DW-1:0]        cfg_rdata_o,
  input  logic [NUM_LINES-1:0] int_n_i,
  input  logic                 nmi_n_i,
  output logic [NUM_LINES-1:0] irq_req_o,
  output logic                 nmi_req_o,
  output logic                 ief1_o,
  output logic                 ief2_o,
  output logic                 pv_o,
  output logic                 pv_we_o,
  output logic [VB_W-1:0]      vec_base_o,
  output logic [DW-1:0]        i_reg_o,
  output logic [EXT_W-1:0]     i_ext_o
);
  irq_ops_t             ops;
  logic                 ief1, ief2;
  logic [NUM_LINES-1:0] req_en;

  always_comb begin
    ops         = '0;
    ops.rst     = op_reset_i;
    ops.nmi_ack = op_nmi_ack_i;
    ops.trap    = op_trap_i;
    ops.int_ack = op_int_ack_i;
    ops.ei      = op_ei_i;
    ops.di      = op_di_i;
    ops.retn    = op_retn_i;
    ops.reti    = op_reti_i;
    ops.ret     = op_ret_i;
    ops.ld_ai   = op_ld_ai_i;
  end

  irq_flag_unit u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ops_i  (ops),
    .ief1_o (ief1),
    .ief2_o (ief2)
  );

  irq_cfg_regs #(
    .NUM_LINES (NUM_LINES),
    .DW        (DW),
    .EXT_W     (EXT_W),
    .VB_W      (VB_W)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (op_reset_i),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .req_en_o (req_en),
    .vbase_o  (vec_base_o),
    .ipage_o  (i_reg_o),
    .iext_o   (i_ext_o)
  );

  irq_line_gate #(
    .NUM_LINES (NUM_LINES)
  ) u_gate (
    .master_en_i (ief1),
    .line_en_i   (req_en),
    .line_n_i    (int_n_i),
    .nmi_n_i     (nmi_n_i),
    .req_o       (irq_req_o),
    .nmi_req_o   (nmi_req_o)
  );

  assign ief1_o  = ief1;
  assign ief2_o  = ief2;
  assign pv_we_o = op_ld_ai_i;
  assign pv_o    = op_ld_ai_i & ief2;
endmodule

// File: rtl/irq_enable_ctrl_chk.sv
module irq_enable_ctrl_chk #(
  parameter int unsigned NUM_LINES = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 op_reset_i,
  input logic                 op_trap_i,
  input logic                 op_nmi_ack_i,
  input logic                 op_int_ack_i,
  input logic                 op_retn_i,
  input logic                 op_reti_i,
  input logic                 op_ret_i,
  input logic                 op_ei_i,
  input logic                 op_di_i,
  input logic                 op_ld_ai_i,
  input logic                 ief1_o,
  input logic                 ief2_o,
  input logic                 pv_o,
  input logic                 pv_we_o,
  input logic [NUM_LINES-1:0] irq_req_o
);
  logic no_evt;
  logic no_instr;
  assign no_evt   = !op_reset_i && !op_nmi_ack_i && !op_trap_i && !op_int_ack_i;
  assign no_instr = !op_ei_i && !op_di_i && !op_retn_i;

  // R1
  reset_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_reset_i |=> (!ief1_o && !ief2_o));

  // R2
  trap_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_trap_i && !op_reset_i && !op_nmi_ack_i) |=> (!ief1_o && !ief2_o));

  // R3
  nmi_saves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_nmi_ack_i && !op_reset_i) |=> (!ief1_o && ief2_o == $past(ief1_o)));

  // R4
  retn_restores_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_retn_i && no_evt && !op_ei_i && !op_di_i)
      |=> (ief1_o == $past(ief2_o) && $stable(ief2_o)));

  // R6
  ei_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_ei_i && no_evt) |=> (ief1_o && ief2_o));

  // R7
  ret_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_reti_i || op_ret_i || op_ld_ai_i) && no_evt && no_instr)
      |=> ($stable(ief1_o) && $stable(ief2_o)));

  // R8
  pv_export_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_ld_ai_i |-> (pv_we_o && pv_o == ief2_o));

  // R12
  gate_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ief1_o |-> (irq_req_o == '0));
endmodule

bind irq_enable_ctrl irq_enable_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .op_reset_i   (op_reset_i),
  .op_trap_i    (op_trap_i),
  .op_nmi_ack_i (op_nmi_ack_i),
  .op_int_ack_i (op_int_ack_i),
  .op_retn_i    (op_retn_i),
  .op_reti_i    (op_reti_i),
  .op_ret_i     (op_ret_i),
  .op_ei_i      (op_ei_i),
  .op_di_i      (op_di_i),
  .op_ld_ai_i   (op_ld_ai_i),
  .ief1_o       (ief1_o),
  .ief2_o       (ief2_o),
  .pv_o         (pv_o),
  .pv_we_o      (pv_we_o),
  .irq_req_o    (irq_req_o)
);

// File: tb/sim_irq_enable_ctrl.sv
module sim_irq_enable_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_reset, op_trap, op_nmi, op_iack, op_retn, op_reti, op_ret, op_ei, op_di, op_ldai;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [3:0] int_n = 4'hF;
  logic nmi_n = 1'b1;
  logic [3:0] irq_req;
  logic nmi_req, ief1, ief2, pv, pv_we;
  logic [6:0] vbase;
  logic [7:0] ireg;
  logic [15:0] iext;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // strobe mask bit positions used by pulse()
  localparam int B_RST = 0, B_TRAP = 1, B_NMI = 2, B_IACK = 3, B_RETN = 4;
  localparam int B_RETI = 5, B_RET = 6, B_EI = 7, B_DI = 8, B_LDAI = 9;

  always #2 clk = ~clk;

  irq_enable_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .op_reset_i(op_reset), .op_trap_i(op_trap), .op_nmi_ack_i(op_nmi),
    .op_int_ack_i(op_iack), .op_retn_i(op_retn), .op_reti_i(op_reti),
    .op_ret_i(op_ret), .op_ei_i(op_ei), .op_di_i(op_di), .op_ld_ai_i(op_ldai),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .int_n_i(int_n), .nmi_n_i(nmi_n),
    .irq_req_o(irq_req), .nmi_req_o(nmi_req), .ief1_o(ief1), .ief2_o(ief2),
    .pv_o(pv), .pv_we_o(pv_we), .vec_base_o(vbase), .i_reg_o(ireg), .i_ext_o(iext)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_ops(input logic [9:0] m);
    op_reset = m[B_RST];  op_trap = m[B_TRAP]; op_nmi = m[B_NMI];
    op_iack  = m[B_IACK]; op_retn = m[B_RETN]; op_reti = m[B_RETI];
    op_ret   = m[B_RET];  op_ei   = m[B_EI];   op_di  = m[B_DI];
    op_ldai  = m[B_LDAI];
  endtask

  // one-cycle strobe; returns at the negedge after the capturing edge
  task automatic pulse(input logic [9:0] m);
    @(negedge clk); set_ops(m);
    @(negedge clk); set_ops('0);
  endtask

  task automatic flags(input string req, input logic e1, input logic e2);
    chk({req, " ief1"}, 32'(ief1), 32'(e1));
    chk({req, " ief2"}, 32'(ief2), 32'(e2));
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk); cfg_addr = a; #1;
    chk(req, 32'(cfg_rdata), 32'(exp));
  endtask

  task automatic t_reset();
    flags("R1 after rst_ni", 1'b0, 1'b0);
    for (int a = 0; a < 5; a++) rd("R1 cfg reset", 3'(a), 8'h00);
    chk("R1 irq_req", 32'(irq_req), 32'h0);
  endtask

  task automatic t_ei_di();
    pulse(10'(1 << B_EI)); flags("R6 EI", 1'b1, 1'b1);
    pulse(10'(1 << B_DI)); flags("R6 DI", 1'b0, 1'b0);
  endtask

  task automatic t_nmi_retn();
    pulse(10'(1 << B_EI));
    pulse(10'(1 << B_NMI));  flags("R3 nmi from enabled", 1'b0, 1'b1);
    pulse(10'(1 << B_RETN)); flags("R4 retn restores 1", 1'b1, 1'b1);
    pulse(10'(1 << B_NMI));
    pulse(10'(1 << B_NMI));  flags("R3 nested nmi saves 0", 1'b0, 1'b0);
    pulse(10'(1 << B_RETN)); flags("R4 retn restores 0", 1'b0, 1'b0);
  endtask

  task automatic t_trap_iack();
    pulse(10'(1 << B_EI)); pulse(10'(1 << B_TRAP)); flags("R2 trap", 1'b0, 1'b0);
    pulse(10'(1 << B_EI)); pulse(10'(1 << B_IACK)); flags("R5 int ack", 1'b0, 1'b0);
  endtask

  task automatic t_hold();
    pulse(10'(1 << B_EI));
    pulse(10'(1 << B_RETI)); flags("R7 reti", 1'b1, 1'b1);
    pulse(10'(1 << B_RET));  flags("R7 ret", 1'b1, 1'b1);
    pulse(10'(1 << B_DI));
    pulse(10'(1 << B_RETI)); flags("R7 reti disabled", 1'b0, 1'b0);
  endtask

  task automatic t_ldai();
    pulse(10'(1 << B_EI)); pulse(10'(1 << B_NMI)); // ief1=0 ief2=1
    @(negedge clk); set_ops(10'(1 << B_LDAI)); #1;
    chk("R8 pv_we", 32'(pv_we), 32'h1);
    chk("R8 pv=ief2 (1)", 32'(pv), 32'h1);
    @(negedge clk); set_ops('0);
    flags("R8 flags kept", 1'b0, 1'b1);
    pulse(10'(1 << B_DI));
    @(negedge clk); set_ops(10'(1 << B_LDAI)); #1;
    chk("R8 pv=ief2 (0)", 32'(pv), 32'h0);
    @(negedge clk); set_ops('0);
    chk("R8 pv_we idle", 32'(pv_we), 32'h0);
  endtask

  task automatic t_cfg();
    wr(3'd0, 8'hFF); rd("R9 req_en upper zero", 3'd0, 8'h0F);
    wr(3'd1, 8'hFF); rd("R10 vbase bit0 zero", 3'd1, 8'hFE);
    chk("R10 vec_base_o", 32'(vbase), 32'h7F);
    wr(3'd1, 8'h52); rd("R10 vbase value", 3'd1, 8'h52);
    chk("R10 vec_base_o value", 32'(vbase), 32'h29);
    wr(3'd2, 8'hA5); rd("R11 ipage", 3'd2, 8'hA5);
    wr(3'd3, 8'h34); wr(3'd4, 8'h12);
    chk("R11 iext", 32'(iext), 32'h1234);
    chk("R11 i_reg_o", 32'(ireg), 32'hA5);
    wr(3'd6, 8'h55); rd("R11 unmapped reads 0", 3'd6, 8'h00);
    rd("R11 unmapped write no effect", 3'd2, 8'hA5);
    rd("R11 unmapped no effect en", 3'd0, 8'h0F);
  endtask

  task automatic t_gate();
    pulse(10'(1 << B_EI));
    @(negedge clk); int_n = 4'b1010; #1;
    chk("R12 gate all enabled", 32'(irq_req), 32'h5);
    wr(3'd0, 8'h03); #1;
    chk("R12 gate partial enable", 32'(irq_req), 32'h1);
    pulse(10'(1 << B_DI)); nmi_n = 1'b0; #1;
    chk("R12 masked by ief1", 32'(irq_req), 32'h0);
    chk("R12 nmi ungated", 32'(nmi_req), 32'h1);
    @(negedge clk); nmi_n = 1'b1; int_n = 4'hF; #1;
    chk("R12 nmi idle", 32'(nmi_req), 32'h0);
  endtask

  task automatic t_prio();
    pulse(10'(1 << B_EI));
    pulse(10'((1 << B_NMI) | (1 << B_TRAP))); flags("R13 nmi over trap", 1'b0, 1'b1);
    pulse(10'(1 << B_EI));
    pulse(10'((1 << B_TRAP) | (1 << B_EI))); flags("R13 trap over EI", 1'b0, 1'b0);
    pulse(10'((1 << B_IACK) | (1 << B_EI))); flags("R13 ack over EI", 1'b0, 1'b0);
    pulse(10'((1 << B_EI) | (1 << B_DI)));   flags("R13 EI over DI", 1'b1, 1'b1);
    pulse(10'(1 << B_NMI));
    pulse(10'((1 << B_DI) | (1 << B_RETN))); flags("R13 DI over RETN", 1'b0, 1'b0);
    pulse(10'(1 << B_EI));
    pulse(10'((1 << B_RST) | (1 << B_NMI))); flags("R13 reset over nmi", 1'b0, 1'b0);
    // soft reset clears config; a coincident write is dropped
    wr(3'd2, 8'h77);
    @(negedge clk); set_ops(10'(1 << B_RST)); cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 8'h0F;
    @(negedge clk); set_ops('0); cfg_we = 1'b0;
    rd("R13 write dropped on reset", 3'd0, 8'h00);
    rd("R1 soft reset clears ipage", 3'd2, 8'h00);
    chk("R1 soft reset clears iext", 32'(iext), 32'h0);
  endtask

  initial begin
    set_ops('0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ei_di();
    t_nmi_retn();
    t_trap_iack();
    t_hold();
    t_ldai();
    t_cfg();
    t_gate();
    t_prio();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule